// File: doc/BRIEF.md
# I2C Master Bus-Condition Generator

This block puts START, RESTART and STOP conditions and one address or data byte at a time on an open-drain two-wire bus. A host sees two byte-wide registers: a shift register holding the byte to send, and a status register whose upper nibble holds the master role, the transmit direction, the bus-busy flag and the pending flag. Bus actions are not started by single command bits. The host writes a whole nibble pattern to the status register, and the block acts on that pattern only when the current state makes it legal. A pattern that is illegal in the current state is discarded, so the SCL and SDA lines are never released early.

The block pulls the lines low through two output enables and samples both lines to find START and STOP conditions, from any master. The bus-busy flag follows those detections. Each SCL half period lasts a number of clock cycles set by a prescaler input. A value of zero gives one cycle.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset both output enables are 0, status reads 0x00 and no bus condition is produced.
- R2: Writing status nibble 0xF (0xF0) is accepted only if the shift register was written since the last byte began. It then produces, each phase one half period long: SCL low with SDA released, both released, SDA low with SCL released (the START/RESTART). It then sends the byte. Without a fresh load the write is ignored.
- R3: The 8 bits go out MSB first. Each bit has one half period with SCL low, then one with SCL released, and SDA does not change while SCL is released. After the byte the shift register reads back its loaded value.
- R4: A ninth bit follows with SDA released. The SDA level sampled at the end of its SCL-high half is stored in status bit 0 (1 = no acknowledge). At the end of the byte status bit 4 (pending) is set and SCL is held low.
- R5: Writing 0xC0 sets status bit 7 (master) and clears bit 6 (transmit). SDA stays released and a held SCL stays low. A later shift-register write releases SCL. While transmit is 1 and SCL is held, a shift-register write sends the next byte with no condition in front of it. Any shift-register write clears pending.
- R6: Writing 0xD0 while master is 1 is a STOP. It is accepted only if it comes 1 to 10 clock edges after the accepted 0xC0; later it is ignored. The STOP holds SCL and SDA low, then releases SCL, then releases SDA, each for one half period. It clears master, transmit and pending.
- R7: Status bit 5 (bus busy) is set 2 cycles after SDA falls while SCL is high, and cleared 2 cycles after SDA rises while SCL is high.
- R8: Writes to either register are discarded while a condition or byte is in progress. After an accepted STOP they are also discarded until the STOP has been seen on the bus. The outputs can still be read during that time.
- R9: Writing 0x00 (slave receive) clears master and transmit and releases a held SCL, but only while pending is 0. A write that clears master and transmit and sets pending (0x10), and any 0x00 while pending is 1, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the shift register, 1 selects the status register |
| wr_data | input | DW | Write data |
| prescale | input | PW | Clock cycles per SCL half period (0 behaves as 1) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| status | output | 8 | {master, transmit, busy, pending, 000, nack} |
| shift_q | output | DW | Shift register contents |

## Verification
A wrong phase state or a wrong half-period count shows up on the two output enables in the first cycle it differs. For that reason the line enables are compared against a timed expectation on every clock. A wrongly decoded write or a lock that is cleared too early does not show up at once. It only shows in the status byte or the shift readback once the sequence has settled, or as waveform entries where the expectation has none. So every discarded write is followed by a settled read of both registers.

// File: rtl/i2ccg_pkg.sv
package i2ccg_pkg;

  typedef enum logic [3:0] {
    E_IDLE, E_HOLD, E_R0, E_R1, E_R2,
    E_BLO, E_BHI, E_ALO, E_AHI, E_S1, E_S2
  } eng_st_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_START, CMD_BYTE, CMD_STOP, CMD_RELEASE
  } eng_cmd_t;

  // status nibble patterns that form host commands
  localparam logic [3:0] OP_RESTART = 4'hF;
  localparam logic [3:0] OP_MTX     = 4'hC;
  localparam logic [3:0] OP_STOP    = 4'hD;
  localparam logic [3:0] OP_SRX     = 4'h0;

endpackage

// File: rtl/i2ccg_monitor.sv
module i2ccg_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_det,
  output logic stop_det,
  output logic bb
);

  logic s_scl_q, s_sda_q, p_scl_q, p_sda_q, bb_q, bb_d;

  assign start_det = p_scl_q & s_scl_q &  p_sda_q & ~s_sda_q;
  assign stop_det  = p_scl_q & s_scl_q & ~p_sda_q &  s_sda_q;
  assign bb        = bb_q;

  always_comb begin
    bb_d = bb_q;
    if (start_det)     bb_d = 1'b1;
    else if (stop_det) bb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_scl_q <= 1'b1;
      s_sda_q <= 1'b1;
      p_scl_q <= 1'b1;
      p_sda_q <= 1'b1;
      bb_q    <= 1'b0;
    end else begin
      s_scl_q <= scl_in;
      s_sda_q <= sda_in;
      p_scl_q <= s_scl_q;
      p_sda_q <= s_sda_q;
      bb_q    <= bb_d;
    end
  end

  AST_BB_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bb_q) else $error("busy not set after start"); // R7
  AST_BB_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bb_q) else $error("busy not cleared after stop"); // R7

endmodule

// File: rtl/i2ccg_engine.sv
module i2ccg_engine
  import i2ccg_pkg::*;
#(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  input  eng_cmd_t      cmd,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          hold,
  output logic          byte_done,
  output logic          nack,
  output logic [DW-1:0] shift_q
);

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  eng_st_t       st_q, st_d;
  logic [PW-1:0] cnt_q, cnt_d, plen_m1;
  logic [BW-1:0] bidx_q, bidx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          nack_q, nack_d, done;

  assign plen_m1 = (prescale == '0) ? '0 : prescale - PW'(1);
  assign done    = (cnt_q == '0);

  always_comb begin
    st_d      = st_q;
    bidx_d    = bidx_q;
    sh_d      = load ? load_data : sh_q;
    nack_d    = nack_q;
    byte_done = 1'b0;
    cnt_d     = done ? cnt_q : cnt_q - PW'(1);
    case (st_q)
      E_IDLE, E_HOLD: begin
        case (cmd)
          CMD_START:   begin st_d = E_R0;  cnt_d = plen_m1; end
          CMD_BYTE:    begin st_d = E_BLO; cnt_d = plen_m1; bidx_d = BW'(DW-1); end
          CMD_STOP:    begin st_d = E_S1;  cnt_d = plen_m1; end
          CMD_RELEASE: st_d = E_IDLE;
          default: ;
        endcase
      end
      E_R0: if (done) begin st_d = E_R1; cnt_d = plen_m1; end
      E_R1: if (done) begin st_d = E_R2; cnt_d = plen_m1; end
      E_R2: if (done) begin st_d = E_BLO; cnt_d = plen_m1; bidx_d = BW'(DW-1); end
      E_BLO: if (done) begin st_d = E_BHI; cnt_d = plen_m1; end
      E_BHI: if (done) begin
        sh_d  = {sh_q[DW-2:0], sh_q[DW-1]};
        cnt_d = plen_m1;
        if (bidx_q == '0) st_d = E_ALO;
        else begin st_d = E_BLO; bidx_d = bidx_q - BW'(1); end
      end
      E_ALO: if (done) begin st_d = E_AHI; cnt_d = plen_m1; end
      E_AHI: if (done) begin
        nack_d    = sda_in;
        byte_done = 1'b1;
        st_d      = E_HOLD;
      end
      E_S1: if (done) begin st_d = E_S2; cnt_d = plen_m1; end
      E_S2: if (done) st_d = E_IDLE;
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      nack_q <= nack_d;
    end
  end

  assign scl_oe  = (st_q == E_HOLD) || (st_q == E_R0) || (st_q == E_BLO) ||
                   (st_q == E_ALO)  || (st_q == E_S1);
  assign sda_oe  = (st_q == E_R2) || (st_q == E_S1) || (st_q == E_S2) ||
                   (((st_q == E_BLO) || (st_q == E_BHI)) && !sh_q[DW-1]);
  assign busy    = (st_q != E_IDLE) && (st_q != E_HOLD);
  assign hold    = (st_q == E_HOLD);
  assign nack    = nack_q;
  assign shift_q = sh_q;

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_BHI && $past(st_q) == E_BHI) |-> $stable(sda_oe))
    else $error("data moved while clock high"); // R3

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2ccg_pkg::*;
#(
  parameter int PW       = 16,
  parameter int DW       = 8,
  parameter int STOP_WIN = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] prescale,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic [7:0]    status,
  output logic [DW-1:0] shift_q
);

  localparam int WW = $clog2(STOP_WIN + 1);

  logic [1:0]    rs_q;
  logic          rst_sn;
  logic          mst_q, mst_d, trx_q, trx_d, pin_q, pin_d;
  logic          addr_q, addr_d, lock_q, lock_d;
  logic [WW-1:0] win_q, win_d;
  logic          ready, eng_busy, eng_hold, byte_done, nack, eng_load;
  logic          start_det, stop_det, bb;
  logic [3:0]    op;
  eng_cmd_t      eng_cmd;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign op    = wr_data[DW-1 -: 4];
  assign ready = !eng_busy && !lock_q;

  always_comb begin
    mst_d    = mst_q;
    trx_d    = trx_q;
    pin_d    = pin_q;
    addr_d   = addr_q;
    lock_d   = lock_q;
    win_d    = (win_q != '0) ? win_q - WW'(1) : win_q;
    eng_cmd  = CMD_NONE;
    eng_load = 1'b0;
    if (stop_det)  lock_d = 1'b0;
    if (byte_done) pin_d  = 1'b1;
    if (wr_en && ready) begin
      if (!wr_sel) begin
        eng_load = 1'b1;
        pin_d    = 1'b0;
        addr_d   = 1'b1;
        if (eng_hold && trx_q) begin
          eng_cmd = CMD_BYTE;
          addr_d  = 1'b0;
        end else if (eng_hold) begin
          eng_cmd = CMD_RELEASE;
        end
      end else begin
        case (op)
          OP_RESTART: if (addr_q) begin
            eng_cmd = CMD_START;
            mst_d   = 1'b1;
            trx_d   = 1'b1;
            pin_d   = 1'b0;
            addr_d  = 1'b0;
          end
          OP_MTX: begin
            mst_d = 1'b1;
            trx_d = 1'b0;
            win_d = WW'(STOP_WIN);
          end
          OP_STOP: if (mst_q && win_q != '0) begin
            eng_cmd = CMD_STOP;
            mst_d   = 1'b0;
            trx_d   = 1'b0;
            pin_d   = 1'b0;
            lock_d  = 1'b1;
          end
          OP_SRX: if (!pin_q) begin
            mst_d = 1'b0;
            trx_d = 1'b0;
            if (eng_hold) eng_cmd = CMD_RELEASE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mst_q  <= 1'b0;
      trx_q  <= 1'b0;
      pin_q  <= 1'b0;
      addr_q <= 1'b0;
      lock_q <= 1'b0;
      win_q  <= '0;
    end else begin
      mst_q  <= mst_d;
      trx_q  <= trx_d;
      pin_q  <= pin_d;
      addr_q <= addr_d;
      lock_q <= lock_d;
      win_q  <= win_d;
    end
  end

  i2ccg_engine #(.PW(PW), .DW(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sn),
    .prescale  (prescale),
    .cmd       (eng_cmd),
    .load      (eng_load),
    .load_data (wr_data),
    .sda_in    (sda_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (eng_busy),
    .hold      (eng_hold),
    .byte_done (byte_done),
    .nack      (nack),
    .shift_q   (shift_q)
  );

  i2ccg_monitor u_monitor (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .start_det (start_det),
    .stop_det  (stop_det),
    .bb        (bb)
  );

  assign status = {mst_q, trx_q, bb, pin_q, 3'b000, nack};

  AST_CMD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_sn)
    (eng_cmd != CMD_NONE) |-> !eng_busy) else $error("command into busy engine"); // R8
  AST_LOCK_FREEZES_ROLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (lock_q && wr_en) |=> ($stable(mst_q) && $stable(trx_q))) else $error("write landed during stop"); // R8
  AST_PIN_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_sn)
    byte_done |=> pin_q) else $error("pending not set"); // R4
  AST_HOLD_ON_PIN: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pin_q) |-> eng_hold) else $error("pending without clock hold"); // R4

endmodule

// File: tb/i2c_cond_gen_test.sv
module i2c_cond_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int P          = 3;

  logic       clk, rst_n, wr_en, wr_sel, scl_ln, sda_ln, scl_oe, sda_oe;
  logic [7:0] wr_data, status, shift_q;
  logic [15:0] prescale;

  i2c_cond_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prescale(prescale), .scl_in(scl_ln), .sda_in(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status), .shift_q(shift_q)
  );

  typedef struct packed { logic scl; logic sda; logic ackw; } ent_t;
  ent_t q[$];

  int    n_vec = 0, n_bad = 0, cyc = 0, block_until = 0, c0_edge = -1000;
  string cur_req = "R1";
  logic  st_scl = 0, st_sda = 0, ack_en = 0, pull = 0;
  logic  m_mst = 0, m_trx = 0, m_bb = 0, m_pin = 0, m_nack = 0, m_addr = 0, m_hold = 0;
  logic [7:0] m_sh = 0;

  initial begin
    clk = 0;
    forever #HALF clk = ~clk;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    ent_t e;
    @(posedge clk);
    cyc++;
    #(HALF);
    if (q.size() > 0) e = q.pop_front();
    else e = '{scl: st_scl, sda: st_sda, ackw: 1'b0};
    chk(cur_req, "line enables", {30'd0, scl_oe, sda_oe}, {30'd0, e.scl, e.sda});
    pull   = ack_en && e.ackw;
    scl_ln = !scl_oe;
    sda_ln = !(sda_oe || pull);
  endtask

  task automatic push(logic s, logic d, logic a);
    repeat (P) q.push_back('{scl: s, sda: d, ackw: a});
  endtask

  task automatic push_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      push(1'b1, !b[i], 1'b0);
      push(1'b0, !b[i], 1'b0);
    end
    push(1'b1, 1'b0, 1'b1);
    push(1'b0, 1'b0, 1'b1);
    m_nack = !ack_en;
    st_scl = 1; st_sda = 0;
  endtask

  task automatic model(logic sel, logic [7:0] d, int e);
    if (!sel) begin
      m_sh = d; m_pin = 0; m_addr = 1;
      if (m_hold && m_trx) begin
        push_byte(d); m_addr = 0; m_pin = 1; block_until = e + 18 * P;
      end else if (m_hold) begin
        m_hold = 0; st_scl = 0; st_sda = 0;
      end
    end else begin
      case (d[7:4])
        4'hF: if (m_addr) begin
          push(1, 0, 0); push(0, 0, 0); push(0, 1, 0);
          push_byte(m_sh);
          m_mst = 1; m_trx = 1; m_pin = 1; m_addr = 0; m_hold = 1; m_bb = 1;
          block_until = e + 21 * P;
        end
        4'hC: begin m_mst = 1; m_trx = 0; c0_edge = e; end
        4'hD: if (m_mst && (e - c0_edge) <= 10) begin
          push(1, 1, 0); push(0, 1, 0);
          st_scl = 0; st_sda = 0;
          m_mst = 0; m_trx = 0; m_pin = 0; m_hold = 0; m_bb = 0;
          block_until = e + 2 * P + 2;
        end
        4'h0: if (!m_pin) begin
          m_mst = 0; m_trx = 0;
          if (m_hold) begin m_hold = 0; st_scl = 0; st_sda = 0; end
        end
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    int e = cyc + 1;
    wr_en = 1; wr_sel = sel; wr_data = d;
    if (e > block_until) model(sel, d, e);
    tick();
    wr_en = 0;
  endtask

  task automatic settle();
    while (cyc <= block_until) tick();
    repeat (3) tick();
  endtask

  task automatic chk_regs(string req);
    chk(req, "status", int'(status), int'({m_mst, m_trx, m_bb, m_pin, 3'b000, m_nack}));
    chk(req, "shift readback", int'(shift_q), int'(m_sh));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; prescale = 16'(P);
    scl_ln = 1; sda_ln = 1;
    cur_req = "R1";
    repeat (3) tick();
    chk_regs("R1");
    rst_n = 1;
    repeat (4) tick();
    chk_regs("R1");

    // start requested with no fresh address: ignored
    cur_req = "R2";
    wr(1, 8'hF0); settle();
    chk_regs("R2");

    // address byte with acknowledge
    cur_req = "R3";
    ack_en = 1;
    wr(0, 8'hA5); wr(1, 8'hF0); settle();
    chk_regs("R4");
    chk("R7", "busy after start", int'(status[5]), 1);

    // data byte without acknowledge, no condition in front
    cur_req = "R5";
    ack_en = 0;
    wr(0, 8'h3C); settle();
    chk_regs("R4");

    // illegal role clears while pending
    cur_req = "R9";
    wr(1, 8'h00); settle(); chk_regs("R9");
    wr(1, 8'h10); settle(); chk_regs("R9");

    // master transmit select, then address load releases clock
    cur_req = "R5";
    wr(1, 8'hC0); settle(); chk_regs("R5");
    wr(0, 8'h5A); settle(); chk_regs("R5");

    cur_req = "R9";
    wr(1, 8'h10); settle(); chk_regs("R9");
    wr(1, 8'h00); settle(); chk_regs("R9");

    // restart with the loaded address
    cur_req = "R2";
    ack_en = 1;
    wr(1, 8'hF0); settle();
    chk_regs("R3");

    // stop one edge too late: ignored
    cur_req = "R6";
    wr(1, 8'hC0);
    repeat (10) tick();
    wr(1, 8'hD0); settle();
    chk_regs("R6");

    // stop on the last edge of the window, then writes during it
    wr(1, 8'hC0);
    repeat (9) tick();
    begin
      int t;
      t = cyc + 1;
      wr(1, 8'hD0);
      cur_req = "R8";
      wr(0, 8'h11);
      while (cyc < t + 2 * P) tick();
      wr(1, 8'hC0);
      wr(0, 8'h77);
    end
    settle();
    chk_regs("R8");
    chk("R7", "busy after stop", int'(status[5]), 0);

    // address consumed by the previous byte: start ignored
    cur_req = "R2";
    wr(1, 8'hF0); settle();
    chk_regs("R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule